// File: doc/BRIEF.md
# External Bus Cycle Controller

This block sequences the processor's external bus transfers independently of instruction execution. The execution side raises a request with a small attribute field (bit 0 marks a write). The controller first checks that the shared bus is free. It then runs an address phase that an address-ready input can stretch, followed by a data phase that a data-ready input can stretch. While it does this it drives an address strobe, a data strobe and a bus-occupied flag, and it reports the end of every transfer with a one-clock done pulse.

The bus counts as free only when the arbiter's grant is high and neither the external busy line nor the external lock line is asserted. At the end of a data phase the controller takes one of three paths. If a new request is waiting and the bus is free, it goes straight into another address phase. If no request is present, it goes back to idle. If a request is waiting but the bus is not free, it parks in a wait state.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge (strobes, busy, done, and `cyc_attr_o` = 0), and the controller is idle.
- R2: Bus free means `grant_i`=1, `bus_busy_i`=0 and `bus_lock_i`=0. A request seen in idle while the bus is not free moves the controller to a wait state with no strobe and `busy_o`=0.
- R3: In idle with `req_i`=0 the controller stays idle and all strobes stay low.
- R4: A request seen in idle with the bus free raises `addr_stb_o` and `busy_o` right after that edge.
- R5: The wait state holds while the bus is not free. It starts the address phase (`addr_stb_o`=1) right after the first edge that sees the bus free. `req_i` is ignored while waiting.
- R6: The address strobe lasts at least two clocks. From its second clock on, `rdy_addr_i` is sampled: if low, the strobe holds; if high, `data_stb_o` replaces it after that edge.
- R7: While `data_stb_o`=1 and `rdy_data_i`=0 at an edge, the data strobe holds and no done pulse is produced.
- R8: The edge that sees `rdy_data_i`=1 during the data strobe ends the transfer. `done_o` is high for exactly the following clock. A transfer with no wait states therefore spans four clocked states, counting the accepting idle state.
- R9: At that ending edge, if `req_i`=1 and the bus is free, `addr_stb_o` rises in the same clock as `done_o`, with no idle clock in between.
- R10: At that ending edge, if `req_i`=0, the controller returns to idle, and `busy_o`=0 while `done_o`=1.
- R11: At that ending edge, if `req_i`=1 and the bus is not free, the controller enters the wait state (no strobe) and later starts the address phase as in R5.
- R12: `req_attr_i` is captured when a request is accepted (in idle, or at a data-phase end with `req_i`=1) and is presented on `cyc_attr_o`. Changes on `req_attr_i` at other times have no effect on it.
- R13: The two strobes are never high together, and `busy_o` is high exactly while one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Transfer request from the execution side |
| req_attr_i | input | ATTR_W | Request attributes, bit 0 = write |
| grant_i | input | 1 | Bus grant from the arbiter |
| bus_busy_i | input | 1 | Another master is using the bus |
| bus_lock_i | input | 1 | The bus is locked by another master |
| rdy_addr_i | input | 1 | Address phase may complete |
| rdy_data_i | input | 1 | Data phase may complete |
| addr_stb_o | output | 1 | Address strobe |
| data_stb_o | output | 1 | Data strobe |
| busy_o | output | 1 | This controller occupies the bus |
| done_o | output | 1 | One-clock end-of-transfer pulse |
| cyc_attr_o | output | ATTR_W | Attributes of the current transfer |

## Verification
A wrong state register shows up at the ports by the next clock. Every output is registered from the next-state decode, so a bad transition changes the strobe pattern one edge after the input that caused it. A missed ready sample either lengthens or shortens a strobe, and a wrong data-phase exit shows as a missing or extra idle clock between `done_o` and the next address strobe. An attribute latched at the wrong time appears on `cyc_attr_o` as soon as the request input changes mid-transfer. A cycle-accurate reference model is compared with every output on every clock.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [2:0] {
        BC_IDLE   = 3'd0,
        BC_WAIT   = 3'd1,
        BC_ASETUP = 3'd2,
        BC_AHOLD  = 3'd3,
        BC_DATA   = 3'd4
    } bc_state_e;

    typedef struct packed {
        logic grant;
        logic busy;
        logic lock;
    } bc_arb_t;

    typedef struct packed {
        logic addr_stb;
        logic data_stb;
        logic occupied;
    } bc_strb_t;

    function automatic logic bus_free(bc_arb_t a);
        return a.grant && !a.busy && !a.lock;
    endfunction

    function automatic bc_strb_t strobe_decode(bc_state_e s);
        bc_strb_t r;
        r.addr_stb = (s == BC_ASETUP) || (s == BC_AHOLD);
        r.data_stb = (s == BC_DATA);
        r.occupied = r.addr_stb || r.data_stb;
        return r;
    endfunction

endpackage

// File: rtl/bcc_next_state.sv
module bcc_next_state
    import bcc_pkg::*;
(
    input  bc_state_e cur,
    input  logic      req,
    input  logic      free,
    input  logic      rdy_addr,
    input  logic      rdy_data,
    output bc_state_e nxt,
    output logic      accept,
    output logic      finish
);
    always_comb begin
        nxt    = cur;
        accept = 1'b0;
        finish = 1'b0;
        unique case (cur)
            BC_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    nxt    = free ? BC_ASETUP : BC_WAIT;
                end
            end
            BC_WAIT: begin
                if (free) nxt = BC_ASETUP;
            end
            BC_ASETUP: nxt = BC_AHOLD;
            BC_AHOLD: begin
                if (rdy_addr) nxt = BC_DATA;
            end
            BC_DATA: begin
                if (rdy_data) begin
                    finish = 1'b1;
                    if (!req) begin
                        nxt = BC_IDLE;
                    end else begin
                        accept = 1'b1;
                        nxt    = free ? BC_ASETUP : BC_WAIT;
                    end
                end
            end
            default: nxt = BC_IDLE;
        endcase
    end
endmodule

// File: rtl/bcc_attr_latch.sv
module bcc_attr_latch #(
    parameter int ATTR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ATTR_W-1:0] attr_in,
    output logic [ATTR_W-1:0] attr_q
);
    for (genvar b = 0; b < ATTR_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)         attr_q[b] <= 1'b0;
            else if (accept) attr_q[b] <= attr_in[b];
        end
    end
endmodule

// File: rtl/bcc_out_reg.sv
module bcc_out_reg
    import bcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bc_state_e nxt,
    input  logic      finish,
    output logic      addr_stb,
    output logic      data_stb,
    output logic      occupied,
    output logic      done
);
    bc_strb_t dec;
    assign dec = strobe_decode(nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_stb <= 1'b0;
            data_stb <= 1'b0;
            occupied <= 1'b0;
            done     <= 1'b0;
        end else begin
            addr_stb <= dec.addr_stb;
            data_stb <= dec.data_stb;
            occupied <= dec.occupied;
            done     <= finish;
        end
    end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int ATTR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ATTR_W-1:0] req_attr_i,
    input  logic              grant_i,
    input  logic              bus_busy_i,
    input  logic              bus_lock_i,
    input  logic              rdy_addr_i,
    input  logic              rdy_data_i,
    output logic              addr_stb_o,
    output logic              data_stb_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [ATTR_W-1:0] cyc_attr_o
);
    bc_state_e state_q;
    bc_state_e state_d;
    bc_arb_t   arb;
    logic      free;
    logic      accept;
    logic      finish;

    assign arb.grant = grant_i;
    assign arb.busy  = bus_busy_i;
    assign arb.lock  = bus_lock_i;
    assign free      = bus_free(arb);

    bcc_next_state u_next (
        .cur      (state_q),
        .req      (req_i),
        .free     (free),
        .rdy_addr (rdy_addr_i),
        .rdy_data (rdy_data_i),
        .nxt      (state_d),
        .accept   (accept),
        .finish   (finish)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= BC_IDLE;
        else     state_q <= state_d;
    end

    bcc_attr_latch #(.ATTR_W(ATTR_W)) u_attr (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .attr_in (req_attr_i),
        .attr_q  (cyc_attr_o)
    );

    bcc_out_reg u_out (
        .clk      (clk),
        .rst      (rst),
        .nxt      (state_d),
        .finish   (finish),
        .addr_stb (addr_stb_o),
        .data_stb (data_stb_o),
        .occupied (busy_o),
        .done     (done_o)
    );
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker
    import bcc_pkg::*;
#(
    parameter int ATTR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input bc_state_e         st,
    input logic              req_i,
    input logic              grant_i,
    input logic              bus_busy_i,
    input logic              bus_lock_i,
    input logic              rdy_addr_i,
    input logic              rdy_data_i,
    input logic              addr_stb_o,
    input logic              data_stb_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [ATTR_W-1:0] cyc_attr_o
);
    logic fr;
    assign fr = grant_i && !bus_busy_i && !bus_lock_i;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (st == BC_IDLE) && !addr_stb_o && !data_stb_o && !busy_o && !done_o);

    assert_nofree_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (st == BC_IDLE && req_i && !fr) |=> (st == BC_WAIT) && !busy_o);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (st == BC_IDLE && !req_i) |=> (st == BC_IDLE) && !addr_stb_o);

    assert_start_R4: assert property (@(posedge clk) disable iff (rst)
        (st == BC_IDLE && req_i && fr) |=> addr_stb_o && busy_o);

    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (st == BC_WAIT && !fr) |=> (st == BC_WAIT) && !busy_o);

    assert_wait_go_R5: assert property (@(posedge clk) disable iff (rst)
        (st == BC_WAIT && fr) |=> (st == BC_ASETUP) && addr_stb_o);

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (st == BC_AHOLD && !rdy_addr_i) |=> (st == BC_AHOLD) && addr_stb_o);

    assert_data_enter_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(data_stb_o) |-> $past(addr_stb_o));

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (data_stb_o && !rdy_data_i) |=> data_stb_o && !done_o);

    assert_done_end_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(data_stb_o) && !data_stb_o);

    assert_chain_R9: assert property (@(posedge clk) disable iff (rst)
        (st == BC_DATA && rdy_data_i && req_i && fr) |=> (st == BC_ASETUP) && done_o);

    assert_to_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (st == BC_DATA && rdy_data_i && !req_i) |=> (st == BC_IDLE) && done_o && !busy_o);

    assert_to_wait_R11: assert property (@(posedge clk) disable iff (rst)
        (st == BC_DATA && rdy_data_i && req_i && !fr) |=> (st == BC_WAIT) && done_o);

    assert_attr_stable_R12: assert property (@(posedge clk) disable iff (rst)
        (st == BC_AHOLD || st == BC_DATA) |-> $stable(cyc_attr_o));

    assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (rst)
        !(addr_stb_o && data_stb_o));
endmodule

bind bus_cycle_ctrl bcc_checker #(.ATTR_W(ATTR_W)) u_bcc_checker (
    .clk        (clk),
    .rst        (rst),
    .st         (state_q),
    .req_i      (req_i),
    .grant_i    (grant_i),
    .bus_busy_i (bus_busy_i),
    .bus_lock_i (bus_lock_i),
    .rdy_addr_i (rdy_addr_i),
    .rdy_data_i (rdy_data_i),
    .addr_stb_o (addr_stb_o),
    .data_stb_o (data_stb_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .cyc_attr_o (cyc_attr_o)
);

// File: tb/test_bus_cycle_ctrl.sv
module test_bus_cycle_ctrl;
    localparam int AW = 2;
    localparam int M_IDLE = 0, M_WAIT = 1, M_SET = 2, M_HOLD = 3, M_DATA = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic [AW-1:0] attr = '0;
    logic grant = 1'b0, bbusy = 1'b0, block = 1'b0, rdya = 1'b0, rdyd = 1'b0;
    logic addr_stb, data_stb, busy, done;
    logic [AW-1:0] cyc_attr;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string tag = "R1";

    int m_st = M_IDLE;
    logic m_done = 1'b0;
    logic [AW-1:0] m_attr = '0;

    always #5 clk = ~clk;

    bus_cycle_ctrl #(.ATTR_W(AW)) i_bus_cycle_ctrl (
        .clk(clk), .rst(rst), .req_i(req), .req_attr_i(attr),
        .grant_i(grant), .bus_busy_i(bbusy), .bus_lock_i(block),
        .rdy_addr_i(rdya), .rdy_data_i(rdyd),
        .addr_stb_o(addr_stb), .data_stb_o(data_stb), .busy_o(busy),
        .done_o(done), .cyc_attr_o(cyc_attr)
    );

    function automatic int ref_next(int s, logic r, logic f, logic ra, logic rd);
        case (s)
            M_IDLE: return r ? (f ? M_SET : M_WAIT) : M_IDLE;
            M_WAIT: return f ? M_SET : M_WAIT;
            M_SET:  return M_HOLD;
            M_HOLD: return ra ? M_DATA : M_HOLD;
            default: return !rd ? M_DATA : (!r ? M_IDLE : (f ? M_SET : M_WAIT));
        endcase
    endfunction

    task automatic model_edge();
        logic f;
        f = grant && !bbusy && !block;
        if (rst) begin
            m_st = M_IDLE; m_done = 1'b0; m_attr = '0;
        end else begin
            if (req && (m_st == M_IDLE || (m_st == M_DATA && rdyd))) m_attr = attr;
            m_done = (m_st == M_DATA) && rdyd;
            m_st = ref_next(m_st, req, f, rdya, rdyd);
        end
    endtask

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("addr_stb", 32'(addr_stb), 32'(m_st == M_SET || m_st == M_HOLD));
        chk("data_stb", 32'(data_stb), 32'(m_st == M_DATA));
        chk("busy", 32'(busy), 32'(m_st >= M_SET));
        chk("done", 32'(done), 32'(m_done));
        chk("cyc_attr", 32'(cyc_attr), 32'(m_attr));
    endtask

    task automatic drive(logic r, logic [AW-1:0] a, logic g, logic b, logic l,
                         logic ra, logic rd);
        req = r; attr = a; grant = g; bbusy = b; block = l; rdya = ra; rdyd = rd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0B5C));
        // R1: reset state, with inputs that would otherwise start a transfer
        tag = "R1"; rst = 1'b1; drive(1, 2'd3, 1, 0, 0, 1, 1);
        repeat (3) step();
        rst = 1'b0;
        // R3: idle without request
        tag = "R3"; drive(0, 2'd2, 1, 0, 0, 1, 1);
        repeat (3) step();
        // R4 / R8 / R10: zero-wait transfer, then return to idle
        tag = "R4"; drive(1, 2'd1, 1, 0, 0, 1, 1); step();
        tag = "R8"; drive(0, 2'd0, 1, 0, 0, 1, 1); repeat (2) step();
        tag = "R10"; repeat (2) step();
        // R2 / R5: unavailable bus via each term, then release
        tag = "R2"; drive(1, 2'd2, 0, 0, 0, 1, 1); step();
        tag = "R5"; drive(0, 2'd3, 0, 0, 0, 1, 1); step();
        drive(1, 2'd3, 1, 1, 0, 1, 1); step();
        drive(0, 2'd1, 1, 0, 1, 1, 1); step();
        drive(0, 2'd1, 1, 0, 0, 0, 0); step();
        // R6: address-ready held low
        tag = "R6"; repeat (3) step();
        drive(0, 2'd0, 1, 0, 0, 1, 0); step();
        // R7: data-ready held low
        tag = "R7"; repeat (3) step();
        // R9: chained transfer, new attributes
        tag = "R9"; drive(1, 2'd2, 1, 0, 0, 0, 1); step();
        // R12: attribute input changes mid-transfer
        tag = "R12"; drive(0, 2'd1, 1, 0, 0, 0, 0); repeat (2) step();
        drive(1, 2'd3, 1, 0, 0, 1, 0); repeat (2) step();
        // R11: end of data with request while bus locked
        tag = "R11"; drive(1, 2'd1, 1, 0, 1, 1, 1); step();
        drive(0, 2'd0, 1, 0, 1, 1, 1); repeat (2) step();
        drive(0, 2'd0, 1, 0, 0, 1, 1); repeat (5) step();
        // R13: constrained random traffic
        tag = "R13";
        for (int i = 0; i < 3000; i++) begin
            drive(($urandom % 100) < 55, AW'($urandom), ($urandom % 100) < 80,
                  ($urandom % 100) < 15, ($urandom % 100) < 10,
                  ($urandom % 100) < 60, ($urandom % 100) < 60);
            step();
            if (addr_stb && data_stb) chk("strobe overlap", 32'd1, 32'd0);
        end
        tag = "R1"; rst = 1'b1; step(); rst = 1'b0;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule